// File: doc/BRIEF.md
# Front Panel Channel Select Display

This block drives the status lamps on the front panel of a four-channel programmable amplifier. A single pushbutton picks which channel is shown. The raw button level is synchronised and debounced against a slow sample tick. Each accepted press moves a 2-bit channel counter forward by one, wrapping from the last channel back to the first. The counter lights one of four channel lamps.

The status lamps show the stored setup of the selected channel, taken from four 7-bit control words held elsewhere. In each word, bits [3:0] hold the gain code, bit 4 the impedance (0 = 1 MΩ, 1 = 50 Ω), bit 5 the coupling (1 = AC), and bit 6 the ground state (1 = disabled and grounded). The four gain lamps copy the gain code. The ground lamp and the AC lamp copy their bits. The high-impedance lamp is the inverse of the impedance bit. The offset setting has no lamp, so it does not enter this block.

Top module: `panel_sel_display`

## Requirements
- R1: After reset, channel lamp pattern `0001` is shown (first channel selected), and the status lamps show control word 0.
- R2: Each accepted press advances the selected channel by exactly one; with no press the selection does not change.
- R3: A press while the last channel is selected (`chan_led_o = 1000`) returns to the first channel (`0001`).
- R4: Exactly one bit of `chan_led_o` is set at all times; bit i marks channel i, and control word i is `ctrl_words_i[7*i+6 : 7*i]`.
- R5: A press is accepted only when the synchronised button has read pressed (1) on `STABLE_TICKS` consecutive `tick_i` samples; a shorter pressed pulse does not change the selection.
- R6: Only the released-to-pressed transition advances the counter: holding the button for any time gives one advance, and the release gives none.
- R7: `gain_led_o` equals bits [3:0] of the selected word, including the boundary codes `0000` (gain 10) and `1001` (gain 0.01).
- R8: `gnd_led_o` equals bit 6 of the selected word.
- R9: `ac_led_o` equals bit 5 of the selected word.
- R10: `hiz_led_o` is the inverse of bit 4 of the selected word.
- R11: A change to a control word that is not selected leaves every lamp output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle sample strobe for the debouncer |
| btn_raw_i | input | 1 | Raw select button level, 1 = pressed, asynchronous |
| ctrl_words_i | input | 28 | Four 7-bit control words, channel i at [7i+6:7i] |
| chan_led_o | output | 4 | One-hot selected-channel lamps |
| gain_led_o | output | 4 | Gain code lamps of the selected channel |
| gnd_led_o | output | 1 | Ground lamp, on when the channel is disabled and grounded |
| ac_led_o | output | 1 | AC coupling lamp |
| hiz_led_o | output | 1 | High-impedance lamp, on for 1 MΩ |

## Verification
The lamps are compared against control words that give each channel a different gain, ground, coupling and impedance pattern. With these words a wrong channel index or a swapped bit shows up as a mismatch. The gain codes include both all-zero and `1001`. The button is driven with full presses, a pulse one tick short of the debounce limit, and a hold lasting many times the limit. These separate a correct debouncer from one that counts too few ticks or fires on level instead of edge. A walk through all four channels and one further press shows the wrap. A rewrite of unselected words shows that the lamps follow only the selected word.

// File: rtl/panel_pkg.sv
package panel_pkg;
  localparam int CTRL_W  = 7;
  localparam int GAIN_W  = 4;
  localparam int IDX_Z   = 4;
  localparam int IDX_AC  = 5;
  localparam int IDX_GND = 6;

  typedef logic [CTRL_W-1:0] ctrl_word_t;

  typedef struct packed {
    logic              gnd;
    logic              ac;
    logic              hiz;
    logic [GAIN_W-1:0] gain;
  } lamp_t;
endpackage

// File: rtl/panel_debounce.sv
module panel_debounce #(
  parameter int STABLE_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic press_o
);
  localparam int CNT_W = $clog2(STABLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STABLE_TICKS - 1);

  logic [1:0]       sync_q;
  logic             stable_q, stable_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flip;

  always_comb begin
    stable_d = stable_q;
    cnt_d    = cnt_q;
    flip     = 1'b0;
    if (tick_i) begin
      if (sync_q[1] == stable_q) begin
        cnt_d = '0;
      end else if (cnt_q == LIMIT) begin
        stable_d = sync_q[1];
        cnt_d    = '0;
        flip     = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  assign press_o = flip & sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync_q   <= {sync_q[0], raw_i};
      stable_q <= stable_d;
      cnt_q    <= cnt_d;
    end
  end

  AST_PRESS_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |-> (tick_i && cnt_q == LIMIT && !stable_q)); // R5
  AST_PRESS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> !press_o); // R6
  AST_PRESS_LEVEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    press_o |=> stable_q); // R6
endmodule

// File: rtl/panel_chan_sel.sv
module panel_chan_sel #(
  parameter int N_CH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    press_i,
  output logic [$clog2(N_CH)-1:0] sel_o,
  output logic [N_CH-1:0]         chan_led_o
);
  localparam int SEL_W = $clog2(N_CH);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_CH - 1);

  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (press_i) begin
      sel_d = (sel_q == LAST) ? '0 : sel_q + SEL_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign chan_led_o[i] = (sel_q == SEL_W'(i));
  end

  assign sel_o = sel_q;

  AST_SEL_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_i && sel_q != LAST) |=> (sel_q == $past(sel_q) + SEL_W'(1))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press_i |=> $stable(sel_q)); // R2
  AST_SEL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (press_i && sel_q == LAST) |=> (chan_led_o[0])); // R3
  AST_CHAN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chan_led_o) == 1); // R4
endmodule

// File: rtl/panel_lamp_map.sv
module panel_lamp_map
  import panel_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic [N_CH*CTRL_W-1:0]  words_i,
  input  logic [$clog2(N_CH)-1:0] sel_i,
  output lamp_t                   lamp_o
);
  ctrl_word_t word_arr [N_CH];
  ctrl_word_t cur;

  for (genvar i = 0; i < N_CH; i++) begin : g_unpack
    assign word_arr[i] = words_i[i*CTRL_W +: CTRL_W];
  end

  always_comb begin
    cur         = word_arr[sel_i];
    lamp_o.gain = cur[GAIN_W-1:0];
    lamp_o.gnd  = cur[IDX_GND];
    lamp_o.ac   = cur[IDX_AC];
    lamp_o.hiz  = ~cur[IDX_Z];
  end
endmodule

// File: rtl/panel_sel_display.sv
module panel_sel_display
  import panel_pkg::*;
#(
  parameter int N_CH         = 4,
  parameter int STABLE_TICKS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   btn_raw_i,
  input  logic [N_CH*CTRL_W-1:0] ctrl_words_i,
  output logic [N_CH-1:0]        chan_led_o,
  output logic [GAIN_W-1:0]      gain_led_o,
  output logic                   gnd_led_o,
  output logic                   ac_led_o,
  output logic                   hiz_led_o
);
  localparam int SEL_W = $clog2(N_CH);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic             press;
  logic [SEL_W-1:0] sel;
  lamp_t            lamp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  panel_debounce #(.STABLE_TICKS(STABLE_TICKS)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tick_i (tick_i),
    .raw_i  (btn_raw_i),
    .press_o(press)
  );

  panel_chan_sel #(.N_CH(N_CH)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .press_i   (press),
    .sel_o     (sel),
    .chan_led_o(chan_led_o)
  );

  panel_lamp_map #(.N_CH(N_CH)) u_map (
    .words_i(ctrl_words_i),
    .sel_i  (sel),
    .lamp_o (lamp)
  );

  assign gain_led_o = lamp.gain;
  assign gnd_led_o  = lamp.gnd;
  assign ac_led_o   = lamp.ac;
  assign hiz_led_o  = lamp.hiz;

  AST_HIZ_INVERTED: assert property (@(posedge clk_i) disable iff (!rst_n)
    hiz_led_o != ctrl_words_i[sel*CTRL_W + IDX_Z]); // R10
  AST_GND_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n)
    gnd_led_o == ctrl_words_i[sel*CTRL_W + IDX_GND]); // R8
  AST_AC_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ac_led_o == ctrl_words_i[sel*CTRL_W + IDX_AC]); // R9
endmodule

// File: tb/panel_sel_display_tb.sv
module panel_sel_display_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH       = 4;
  localparam int STABLE     = 4;
  localparam int TICK_DIV   = 3;

  typedef struct {
    logic [3:0] chan;
    logic [3:0] gain;
    logic       gnd;
    logic       ac;
    logic       hiz;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        tick_i;
  logic        btn_raw_i;
  logic [27:0] ctrl_words_i;
  logic [3:0]  chan_led_o;
  logic [3:0]  gain_led_o;
  logic        gnd_led_o, ac_led_o, hiz_led_o;

  logic [6:0]  words [N_CH];
  int          exp_sel;
  int          checks = 0;
  int          errors = 0;
  exp_t        sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ctrl_words_i = {words[3], words[2], words[1], words[0]};

  panel_sel_display #(.N_CH(N_CH), .STABLE_TICKS(STABLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .btn_raw_i(btn_raw_i),
    .ctrl_words_i(ctrl_words_i), .chan_led_o(chan_led_o), .gain_led_o(gain_led_o),
    .gnd_led_o(gnd_led_o), .ac_led_o(ac_led_o), .hiz_led_o(hiz_led_o)
  );

  initial begin
    tick_i = 1'b0;
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
    end
  end

  // driver: push expected lamps from the bench model of the requirements
  task automatic expect_lamps(input string tag);
    exp_t e;
    e.chan = 4'b0001 << exp_sel;
    e.gain = words[exp_sel][3:0];
    e.gnd  = words[exp_sel][6];
    e.ac   = words[exp_sel][5];
    e.hiz  = ~words[exp_sel][4];
    e.tag  = tag;
    @(posedge clk); #1;
    sb_q.push_back(e);
    @(negedge clk); @(negedge clk);
  endtask

  // monitor: pop and compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if ({chan_led_o, gain_led_o, gnd_led_o, ac_led_o, hiz_led_o} !==
            {e.chan, e.gain, e.gnd, e.ac, e.hiz}) begin
          errors++;
          $display("FAIL %s chan=%b gain=%b gnd=%b ac=%b hiz=%b exp chan=%b gain=%b gnd=%b ac=%b hiz=%b",
                   e.tag, chan_led_o, gain_led_o, gnd_led_o, ac_led_o, hiz_led_o,
                   e.chan, e.gain, e.gnd, e.ac, e.hiz);
        end
        checks++;
        if ($countones(chan_led_o) != 1) begin
          errors++;
          $display("FAIL R4 chan=%b exp one-hot", chan_led_o);
        end
      end
    end
  end

  task automatic hold_btn(input logic lvl, input int ticks);
    btn_raw_i = lvl;
    repeat (ticks * TICK_DIV) @(posedge clk);
    #1;
  endtask

  task automatic press_once();
    hold_btn(1'b1, STABLE + 3);
    hold_btn(1'b0, STABLE + 3);
    exp_sel = (exp_sel + 1) % N_CH;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    btn_raw_i = 1'b0;
    exp_sel   = 0;
    words[0]  = 7'b000_0000;   // gain 10, 1 MOhm, DC, enabled
    words[1]  = 7'b101_1001;   // gain 0.01, 50 Ohm, DC, grounded
    words[2]  = 7'b010_0011;   // AC coupled, 1 MOhm
    words[3]  = 7'b111_0110;   // all flags set
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    expect_lamps("R1 reset selects first channel, R7 gain 0000, R10 hiz on");

    press_once();
    expect_lamps("R2 advance to channel 2, R7 gain 1001, R8 gnd, R10 hiz off");
    press_once();
    expect_lamps("R2 advance to channel 3, R9 ac on");
    press_once();
    expect_lamps("R2 advance to channel 4, R8 R9 R10 all flags");
    press_once();
    expect_lamps("R3 wrap from channel 4 to channel 1");

    // short pulse: one tick below the limit
    hold_btn(1'b1, STABLE - 1);
    hold_btn(1'b0, STABLE + 3);
    expect_lamps("R5 short pulse ignored");
    hold_btn(1'b1, 1);
    hold_btn(1'b0, 2);
    hold_btn(1'b1, STABLE - 2);
    hold_btn(1'b0, STABLE + 3);
    expect_lamps("R5 bouncing pulses ignored");

    // long hold: one advance only
    hold_btn(1'b1, STABLE * 8);
    exp_sel = 1;
    expect_lamps("R6 long hold gives one advance");
    hold_btn(1'b0, STABLE * 4);
    expect_lamps("R6 release gives no advance");

    // unselected words change
    words[0] = 7'b111_1111;
    words[2] = 7'b111_1000;
    words[3] = 7'b000_0001;
    #1;
    expect_lamps("R11 unselected words do not touch lamps");

    // selected word change
    words[1] = 7'b010_0101;
    #1;
    expect_lamps("R7 R9 R10 selected word change shown");
    words[1] = 7'b100_1010;
    #1;
    expect_lamps("R8 selected word ground bit shown");

    press_once();
    expect_lamps("R2 advance to channel 3 after rewrite");

    repeat (4) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule